// File: doc/BRIEF.md
# Serial Coefficient Staging Buffer Loader

This block is the slave side of a four-wire serial port. It lets a host stage a batch of coefficient words while the signal path keeps running. The host first sends 16-clock register frames. These frames clear the word counter, seed an 8-bit checksum, and load a 21-bit start address. The last address frame also sets a memory-mode flag. From then until chip select rises, every 32 serial clocks carry one data word, least significant bit first. Each complete word goes into the next slot of a 32-entry staging buffer. The main coefficient memory is never touched here. A separate commit engine reads the buffer through a random-access read port, together with the word count, start address and checksum seed.

All serial inputs are sampled in the system clock domain. A rising serial clock is detected on the registered copy. A word or frame that chip select cuts short is dropped, and the bit counter starts again in the next session. Once the counter reaches the buffer depth, further words are discarded and the counter stays where it is.

Top module: `scsb_loader`

## Requirements
- R1: After reset, word_count is 0, start_addr is 0, checksum is 0, mem_mode is 0 and rd_valid is 0 for every index.
- R2: While mem_mode is 0, each 16 serial clocks form one frame, most significant bit first. Frame bits [15:8] select a register and bits [7:0] carry data. A frame with an unlisted selector changes nothing.
- R3: Selector 0x10 writes start_addr[7:0]. Selector 0x11 writes start_addr[15:8]. Selector 0x12 writes start_addr[20:16] from data bits [4:0] and sets mem_mode from data bit 7.
- R4: Selector 0x01 clears word_count to 0. Selector 0x10 (a new setup) also clears word_count. Either way, every staged word becomes invalid.
- R5: Selector 0x02 loads checksum with the data byte.
- R6: While mem_mode is 1, each 32 serial clocks form one word, least significant bit first. The word is stored at buffer index word_count, and word_count then increments.
- R7: word_count saturates at 32. Words received at that count are discarded and leave all buffer entries unchanged.
- R8: If chip select rises before the last bit of a word or frame, the partial word or frame is discarded and word_count is unchanged. The next session starts at bit 0.
- R9: Chip select high clears mem_mode, so each session begins in register mode.
- R10: rd_valid is 1 exactly when rd_idx < word_count, and rd_data then returns the word stored at rd_idx.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in |
| rd_idx | input | 5 | Buffer read index |
| rd_data | output | 32 | Word stored at rd_idx |
| rd_valid | output | 1 | rd_idx holds a staged word |
| word_count | output | 6 | Number of staged words |
| start_addr | output | 21 | Start address for the commit |
| checksum | output | 8 | Checksum seed |
| mem_mode | output | 1 | Port is in memory-access mode |

## Verification
A wrong bit counter shows up as shifted or rotated words in rd_data. The same fault can also move word_count by one, which becomes visible a few system clocks after chip select rises. A wrong count state shows up at once in rd_valid across the index sweep, and in saturation: a 33rd write would overwrite entry 0 or wrap the count. A stale mode flag makes the next session treat its register frames as data. That bumps word_count instead of updating start_addr or checksum.

// File: rtl/scsb_pkg.sv
package scsb_pkg;
    localparam int unsigned FRAME_W = 16;
    localparam logic [7:0] SEL_CNT_CLR = 8'h01;
    localparam logic [7:0] SEL_CHK     = 8'h02;
    localparam logic [7:0] SEL_ADR_LO  = 8'h10;
    localparam logic [7:0] SEL_ADR_MID = 8'h11;
    localparam logic [7:0] SEL_ADR_HI  = 8'h12;
endpackage

// File: rtl/scsb_sync.sv
module scsb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic active,
    output logic rise,
    output logic bit_s
);
    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic sdi;
        logic sclk_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.cs_n      = cs_n;
        s_d.sclk      = sclk;
        s_d.sdi       = sdi;
        s_d.sclk_prev = s_q.sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cs_n: 1'b1, sclk: 1'b0, sdi: 1'b0, sclk_prev: 1'b0};
        else        s_q <= s_d;
    end

    assign active = !s_q.cs_n;
    assign rise   = s_q.sclk && !s_q.sclk_prev;
    assign bit_s  = s_q.sdi;
endmodule

// File: rtl/scsb_shift.sv
module scsb_shift #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned FRAME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              rise,
    input  logic              bit_in,
    input  logic              word_mode,
    output logic              done,
    output logic              is_word,
    output logic [WORD_W-1:0] data
);
    localparam int unsigned BC_W = $clog2(WORD_W + 1);
    localparam logic [BC_W-1:0] WORD_LEN  = BC_W'(WORD_W);
    localparam logic [BC_W-1:0] FRAME_LEN = BC_W'(FRAME_W);

    typedef struct packed {
        logic [BC_W-1:0]   cnt;
        logic [WORD_W-1:0] sh;
        logic              done;
        logic              is_word;
        logic [WORD_W-1:0] data;
    } shift_t;

    shift_t s_d, s_q;
    logic [WORD_W-1:0] nsh;
    logic [BC_W-1:0]   ncnt;
    logic [BC_W-1:0]   target;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        // Data words arrive LSB first; register frames arrive MSB first.
        nsh      = word_mode ? {bit_in, s_q.sh[WORD_W-1:1]}
                             : {s_q.sh[WORD_W-2:0], bit_in};
        ncnt     = s_q.cnt + 1'b1;
        target   = word_mode ? WORD_LEN : FRAME_LEN;
        if (!active) begin
            s_d.cnt = '0;
        end else if (rise) begin
            s_d.sh = nsh;
            if (ncnt == target) begin
                s_d.cnt     = '0;
                s_d.done    = 1'b1;
                s_d.is_word = word_mode;
                s_d.data    = nsh;
            end else begin
                s_d.cnt = ncnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done    = s_q.done;
    assign is_word = s_q.is_word;
    assign data    = s_q.data;
endmodule

// File: rtl/scsb_store.sv
module scsb_store #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [WORD_W-1:0]        rdata
);
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/scsb_loader.sv
module scsb_loader #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 21
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         sclk,
    input  logic                         sdi,
    input  logic [$clog2(DEPTH)-1:0]     rd_idx,
    output logic [WORD_W-1:0]            rd_data,
    output logic                         rd_valid,
    output logic [$clog2(DEPTH):0]       word_count,
    output logic [ADDR_W-1:0]            start_addr,
    output logic [7:0]                   checksum,
    output logic                         mem_mode
);
    import scsb_pkg::*;

    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = IDX_W + 1;
    localparam int unsigned HI_W  = ADDR_W - 16;
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        chk;
        logic              mode;
    } ctl_t;

    ctl_t c_d, c_q;

    logic              active, rise, bit_s;
    logic              done, is_word;
    logic [WORD_W-1:0] data;
    logic              we;
    logic [IDX_W-1:0]  waddr;

    scsb_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdi    (sdi),
        .active (active),
        .rise   (rise),
        .bit_s  (bit_s)
    );

    scsb_shift #(.WORD_W(WORD_W), .FRAME_W(FRAME_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .rise      (rise),
        .bit_in    (bit_s),
        .word_mode (c_q.mode),
        .done      (done),
        .is_word   (is_word),
        .data      (data)
    );

    scsb_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (data),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    always_comb begin
        c_d   = c_q;
        we    = 1'b0;
        waddr = c_q.count[IDX_W-1:0];
        if (done) begin
            if (is_word) begin
                if (c_q.count < FULL) begin
                    we      = 1'b1;
                    c_d.count = c_q.count + 1'b1;
                end
            end else begin
                case (data[15:8])
                    SEL_CNT_CLR: c_d.count = '0;
                    SEL_CHK:     c_d.chk = data[7:0];
                    SEL_ADR_LO: begin
                        c_d.addr[7:0] = data[7:0];
                        c_d.count     = '0;
                    end
                    SEL_ADR_MID: c_d.addr[15:8] = data[7:0];
                    SEL_ADR_HI: begin
                        c_d.addr[ADDR_W-1:16] = data[HI_W-1:0];
                        c_d.mode              = data[7];
                    end
                    default: ;
                endcase
            end
        end
        // Session end overrides any mode set in the same cycle.
        if (!active) c_d.mode = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign word_count = c_q.count;
    assign start_addr = c_q.addr;
    assign checksum   = c_q.chk;
    assign mem_mode   = c_q.mode;
    assign rd_valid   = {1'b0, rd_idx} < c_q.count;
endmodule

// File: rtl/scsb_loader_chk.sv
module scsb_loader_chk #(
    parameter int unsigned DEPTH = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cs_n,
    input logic [$clog2(DEPTH):0] word_count,
    input logic                   rd_valid,
    input logic                   mem_mode
);
    localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

    // R7: the count never passes the buffer depth.
    a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        word_count <= CNT_W'(DEPTH));

    // R6 / R4: the count moves only up by one or back to zero.
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count != $past(word_count)) |->
        (word_count == $past(word_count) + 1'b1 || word_count == '0));

    // R9: a sustained high chip select leaves the port in register mode.
    a_r9_mode_drop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 2) && $past(cs_n)) |-> !mem_mode);

    // R8: with chip select held high, the count does not move.
    a_r8_idle_count: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n, 4) && $past(cs_n, 3) && $past(cs_n, 2) && $past(cs_n))
        |-> $stable(word_count));

    // R10: an empty buffer reports no valid entry.
    a_r10_empty_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count == '0) |-> !rd_valid);
endmodule

bind scsb_loader scsb_loader_chk #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .word_count (word_count),
    .rd_valid   (rd_valid),
    .mem_mode   (mem_mode)
);

// File: tb/scsb_loader_test.sv
module scsb_loader_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [5:0]  word_count;
    logic [20:0] start_addr;
    logic [7:0]  checksum;
    logic        mem_mode;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [31:0] model [32];

    always #10 clk = ~clk;

    scsb_loader uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_valid(rd_valid),
        .word_count(word_count), .start_addr(start_addr),
        .checksum(checksum), .mem_mode(mem_mode)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input int i);
        return (32'h9E3779B9 * (i + 1)) ^ (32'h01010101 << (i % 8));
    endfunction

    task automatic bit_out(input logic b);
        @(negedge clk); sdi = b; sclk = 1'b0;
        repeat (3) @(negedge clk);
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic cs_lo();
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic cs_hi();
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] sel, input logic [7:0] dat, input int nbits);
        logic [15:0] v = {sel, dat};
        for (int i = 15; i > 15 - nbits; i--) bit_out(v[i]);
    endtask

    task automatic word(input logic [31:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) bit_out(w[i]);
    endtask

    task automatic mode_on(input logic [20:0] a);
        frame(8'h12, {1'b1, 2'b00, a[20:16]}, 16);
        repeat (6) @(negedge clk);
    endtask

    task automatic sweep(input int n, input string req);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk); rd_idx = 5'(i);
            #1;
            chk(rd_valid == (i < n), "R10", {31'b0, rd_valid}, {31'b0, i < n});
            if (i < n) chk(rd_data == model[i], req, rd_data, model[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [20:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        chk(word_count == 0, "R1", 32'(word_count), 0);
        chk(start_addr == 0, "R1", 32'(start_addr), 0);
        chk(checksum == 0, "R1", 32'(checksum), 0);
        chk(mem_mode == 0, "R1", 32'(mem_mode), 0);
        sweep(0, "R1");

        // R5 checksum load, R2 unknown selector ignored
        cs_lo(); frame(8'h02, 8'h5A, 16); frame(8'h33, 8'hFF, 16); cs_hi();
        chk(checksum == 8'h5A, "R5", 32'(checksum), 32'h5A);
        chk(start_addr == 0 && word_count == 0, "R2", 32'(start_addr), 0);

        // R3 address sweep across sessions
        for (int k = 0; k < 8; k++) begin
            a = 21'((k * 32'h2F0F1 + 3) & 32'h1FFFFF);
            cs_lo(); frame(8'h10, a[7:0], 16); frame(8'h11, a[15:8], 16);
            frame(8'h12, {3'b000, a[20:16]}, 16); cs_hi();
            chk(start_addr == a, "R3", 32'(start_addr), 32'(a));
            chk(mem_mode == 0, "R3", 32'(mem_mode), 0);
        end

        // R6 full setup then 10 words
        a = 21'h1ABCDE;
        cs_lo(); frame(8'h01, 8'h00, 16); frame(8'h02, 8'h00, 16);
        frame(8'h10, a[7:0], 16); frame(8'h11, a[15:8], 16); mode_on(a);
        chk(mem_mode == 1, "R3", 32'(mem_mode), 1);
        for (int i = 0; i < 10; i++) begin model[i] = pattern(i); word(model[i], 32); end
        cs_hi();
        chk(mem_mode == 0, "R9", 32'(mem_mode), 0);
        chk(word_count == 10, "R6", 32'(word_count), 10);
        chk(start_addr == a && checksum == 0, "R3", 32'(start_addr), 32'(a));
        sweep(10, "R6");

        // R9: next session is register mode; a frame does not add a word
        cs_lo(); frame(8'h02, 8'hC3, 16); cs_hi();
        chk(word_count == 10, "R9", 32'(word_count), 10);
        chk(checksum == 8'hC3, "R9", 32'(checksum), 32'hC3);

        // R7 fill to 32, then extra words ignored
        cs_lo(); mode_on(a);
        for (int i = 10; i < 32; i++) begin model[i] = pattern(i); word(model[i], 32); end
        for (int i = 0; i < 3; i++) word(~pattern(i), 32);
        cs_hi();
        chk(word_count == 32, "R7", 32'(word_count), 32);
        sweep(32, "R7");

        // R4 count clear invalidates everything
        cs_lo(); frame(8'h01, 8'h00, 16); cs_hi();
        chk(word_count == 0, "R4", 32'(word_count), 0);
        sweep(0, "R4");

        // R8 partial word dropped, restart at bit 0
        cs_lo(); mode_on(a);
        model[0] = 32'hDEADBEEF; model[1] = 32'h0F1E2D3C;
        word(model[0], 32); word(model[1], 32); word(32'hFFFFFFFF, 31);
        cs_hi();
        chk(word_count == 2, "R8", 32'(word_count), 2);
        cs_lo(); mode_on(a); model[2] = 32'h80000001; word(model[2], 32); cs_hi();
        chk(word_count == 3, "R8", 32'(word_count), 3);
        sweep(3, "R8");

        // R8 partial frame dropped
        cs_lo(); frame(8'h02, 8'h77, 10); cs_hi();
        chk(checksum == 8'hC3, "R8", 32'(checksum), 32'hC3);

        // R4 new setup via low address byte clears count
        cs_lo(); frame(8'h10, 8'h44, 16); cs_hi();
        chk(word_count == 0, "R4", 32'(word_count), 0);
        chk(start_addr == {a[20:8], 8'h44}, "R3", 32'(start_addr), 32'({a[20:8], 8'h44}));

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule